// File: doc/BRIEF.md
# Bidirectional Printer Port Register File

This block holds the three byte-wide host-visible registers of a classic PC printer port that can also turn its data lines around. A host reaches it through a single-beat request channel: a byte write or read at one of three consecutive addresses starting at a configurable base. The block drives eight data pins with output enables and four open-collector control pins, and it samples five status lines from the attached device.

Every read returns what is actually on the wires, not what was last written. Data, control and status pins all pass through a two-flop synchronizer before reaching the read path. A bit in the control register releases the data drivers so that an external device can drive the data lines. Three of the four control outputs are inverted between the register bit and the pin level. The same inversion is applied when those pins are read back, so the four lines can also serve as extra inputs once software releases them.

Request channel rules: `bus_ready` is held high, so every cycle with `bus_valid` high is one accepted transfer and the channel never applies back-pressure. A read to a decoded offset returns `rsp_valid` for exactly one cycle, one cycle after it is accepted. The response channel has no ready signal, and the host must take the response in that cycle. Writes and accesses outside the three decoded offsets produce no response.

Top module: `pport_regs`

## Requirements
- R1: After reset the data latch is 0x00 and its pins are driven (`dpin_oe` = 0xFF). The control register holds 0x04, no control pin is pulled low, and a control read with nothing external returns 0xC4.
- R2: A write to offset 0 appears on `dpin_out` in the cycle after acceptance. It stays unchanged through writes to any other offset until the next offset-0 write.
- R3: A read of offset 0 returns the synchronized data pin levels, not the latch. A read accepted one or two cycles after a data write returns the previous pin state, and a read accepted three cycles after it returns the new byte.
- R4: Control bit 5 = 1 sets all eight `dpin_oe` bits to 0, which is input mode. Control bit 5 = 0 sets all eight to 1.
- R5: Control bits 7 and 6 always read as 1 and ignore writes. Bits 5 and 4 read back exactly as last written.
- R6: Control bits 0, 1 and 3 are inverted and bit 2 is not. The pin level is `ctrl[i] ^ 4'b1011[i]`, and `cpin_pull_low[i]` is 1 exactly when that level is low. Writing 0x0B pulls all four pins low, 0x01 gives 4'b0101, and any value with low nibble 0100 releases all four.
- R7: Control read bits 3..0 equal the synchronized control pin levels XOR 4'b1011. An external pull-down therefore shows even when the register bit says otherwise.
- R8: A status read returns {~stat_in[4], stat_in[3:0], 3'b111}. Writes to offset 1 change nothing.
- R9: Accesses at offsets 3 and above, relative to the base, give no response and change neither the data pins nor the control pins.
- R10: `bus_ready` is always 1. `rsp_valid` rises one cycle after each accepted decoded read and never after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 8 | Read response byte |
| dpin_out | output | 8 | Data pin output levels |
| dpin_oe | output | 8 | Data pin output enables |
| dpin_in | input | 8 | Data pin sensed levels |
| cpin_pull_low | output | 4 | Control pin open-collector pull-down |
| cpin_in | input | 4 | Control pin sensed levels |
| stat_in | input | 5 | Status lines from the device |

## Verification
Two things can happen in the same cycle window: the data latch is updated, and the read path samples the data pins through the synchronizer. The bench issues a data write followed at once by back-to-back data reads, with the pins looped back the way a real pad would return them. The first two reads must return the old byte and the third must return the new one. The bench also overlaps a control write that switches to input mode with an external byte on the pins, and expects a data read to return the external byte while the latch keeps its own value.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int DATA_W      = 8;
  localparam int CTL_PINS    = 4;
  localparam int STAT_PINS   = 5;
  localparam int CTL_STORE_W = 6;
  localparam int MODE_BIT    = 5;

  // pin level = register bit XOR this mask (bits 0, 1, 3 inverted)
  localparam logic [CTL_PINS-1:0]    CTL_INV   = 4'b1011;
  localparam logic [CTL_STORE_W-1:0] CTL_RESET = 6'b000100;
  localparam logic [DATA_W-1:0]      DATA_RESET = 8'h00;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pport_decode.sv
module pport_decode
  import pport_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0300
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int NUM_REGS = 3;

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - BASE_ADDR;
    if (offset < ADDR_W'(NUM_REGS)) sel = reg_sel_e'(offset[1:0]);
    else                            sel = SEL_NONE;
  end
endmodule

// File: rtl/pport_latch.sv
module pport_latch
  import pport_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  reg_sel_e               sel,
  input  logic [DATA_W-1:0]      wdata,
  output logic [CTL_STORE_W-1:0] ctrl_q,
  output logic [DATA_W-1:0]      dpin_out,
  output logic [DATA_W-1:0]      dpin_oe,
  output logic [CTL_PINS-1:0]    cpin_pull_low
);
  logic [DATA_W-1:0]   data_q;
  logic [CTL_PINS-1:0] ctl_level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= DATA_RESET;
      ctrl_q <= CTL_RESET;
    end else if (wr_en) begin
      case (sel)
        SEL_DATA: data_q <= wdata;
        SEL_CTRL: ctrl_q <= wdata[CTL_STORE_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    ctl_level     = ctrl_q[CTL_PINS-1:0] ^ CTL_INV;
    cpin_pull_low = ~ctl_level;
    dpin_out      = data_q;
    dpin_oe       = {DATA_W{~ctrl_q[MODE_BIT]}};
  end

  // R2: data latch only moves on a data write
  a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_DATA) |=> $stable(dpin_out));
  a_r2_data_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DATA) |=> dpin_out == $past(wdata));
  // R4: setting the mode bit releases every data driver
  a_r4_input_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_CTRL && wdata[MODE_BIT]) |=> dpin_oe == '0);
  // R6: low nibble 0100 releases all control pins
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_CTRL && wdata[3:0] == 4'b0100) |=> cpin_pull_low == '0);
endmodule

// File: rtl/pport_readmux.sv
module pport_readmux
  import pport_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  reg_sel_e             sel,
  input  logic [DATA_W-1:0]    data_sync,
  input  logic [STAT_PINS-1:0] stat_sync,
  input  logic [CTL_PINS-1:0]  ctl_sync,
  input  logic [1:0]           ctrl_hi,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_data
);
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] stat_view;
  logic [DATA_W-1:0] pick;

  always_comb begin
    ctrl_view = {2'b11, ctrl_hi, ctl_sync ^ CTL_INV};
    stat_view = {~stat_sync[STAT_PINS-1], stat_sync[STAT_PINS-2:0], 3'b111};
    case (sel)
      SEL_DATA: pick = data_sync;
      SEL_STAT: pick = stat_view;
      SEL_CTRL: pick = ctrl_view;
      default:  pick = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en && (sel != SEL_NONE);
      if (rd_en) rsp_data <= pick;
    end
  end

  // R5: top two control bits always read as ones
  a_r5_ctrl_top_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(sel == SEL_CTRL)) |-> rsp_data[7:6] == 2'b11);
  // R8: low three status bits always read as ones
  a_r8_stat_low_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(sel == SEL_STAT)) |-> rsp_data[2:0] == 3'b111);
  // R10: a response is always caused by a read one cycle earlier
  a_r10_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_en));
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0300,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic [7:0]        dpin_out,
  output logic [7:0]        dpin_oe,
  input  logic [7:0]        dpin_in,
  output logic [3:0]        cpin_pull_low,
  input  logic [3:0]        cpin_in,
  input  logic [4:0]        stat_in
);
  localparam int SYNC_W = DATA_W + STAT_PINS + CTL_PINS;

  reg_sel_e                 sel;
  logic                     accept;
  logic                     wr_en;
  logic                     rd_en;
  logic [CTL_STORE_W-1:0]   ctrl_q;
  logic [SYNC_W-1:0]        raw_pins;
  logic [SYNC_W-1:0]        sync_pins;
  logic [DATA_W-1:0]        data_sync;
  logic [STAT_PINS-1:0]     stat_sync;
  logic [CTL_PINS-1:0]      ctl_sync;

  assign bus_ready = 1'b1;
  assign accept    = bus_valid && bus_ready;
  assign wr_en     = accept && bus_write;
  assign rd_en     = accept && !bus_write;

  pport_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  pport_latch u_latch (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .sel           (sel),
    .wdata         (bus_wdata),
    .ctrl_q        (ctrl_q),
    .dpin_out      (dpin_out),
    .dpin_oe       (dpin_oe),
    .cpin_pull_low (cpin_pull_low)
  );

  assign raw_pins = {dpin_in, stat_in, cpin_in};

  pport_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_pins),
    .q     (sync_pins)
  );

  assign data_sync = sync_pins[SYNC_W-1 -: DATA_W];
  assign stat_sync = sync_pins[CTL_PINS +: STAT_PINS];
  assign ctl_sync  = sync_pins[CTL_PINS-1:0];

  pport_readmux u_readmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .sel       (sel),
    .data_sync (data_sync),
    .stat_sync (stat_sync),
    .ctl_sync  (ctl_sync),
    .ctrl_hi   (ctrl_q[5:4]),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // R9: undecoded writes leave every pin output alone
  a_r9_miss_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && sel == SEL_NONE)
      |=> ($stable(dpin_out) && $stable(dpin_oe) && $stable(cpin_pull_low)));
  // R10: each decoded read is answered in the next cycle
  a_r10_rsp_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && sel != SEL_NONE) |=> rsp_valid);
  a_r10_no_rsp_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |=> !rsp_valid);
endmodule

// File: tb/pport_regs_test.sv
`timescale 1ns/1ps
module pport_regs_test;
  localparam int          ADDR_W = 16;
  localparam logic [15:0] BASE   = 16'h0300;

  typedef struct packed {
    logic       wr;
    logic [1:0] off;
    logic [7:0] wd;
    logic [7:0] ext;
    logic [3:0] pull;
    logic [4:0] st;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 8'h00, 8'h00, 4'h0, 5'h00, 8'hC4, 4'd1},  // R1 ctrl reset view
    '{1'b0, 2'd0, 8'h00, 8'h00, 4'h0, 5'h00, 8'h00, 4'd1},  // R1 data reset view
    '{1'b1, 2'd0, 8'hA5, 8'h00, 4'h0, 5'h00, 8'h00, 4'd2},
    '{1'b0, 2'd0, 8'h00, 8'h00, 4'h0, 5'h00, 8'hA5, 4'd3},  // R3 loopback
    '{1'b1, 2'd2, 8'h20, 8'h3C, 4'h0, 5'h00, 8'h00, 4'd4},
    '{1'b0, 2'd0, 8'h00, 8'h3C, 4'h0, 5'h00, 8'h3C, 4'd3},  // R3 external byte
    '{1'b0, 2'd2, 8'h00, 8'h3C, 4'h0, 5'h00, 8'hE0, 4'd7},  // R7
    '{1'b1, 2'd2, 8'h14, 8'h00, 4'h0, 5'h00, 8'h00, 4'd5},
    '{1'b0, 2'd2, 8'h00, 8'h00, 4'h2, 5'h00, 8'hD6, 4'd7},  // R7 pin1 pulled
    '{1'b1, 2'd2, 8'hFF, 8'h00, 4'h0, 5'h00, 8'h00, 4'd5},
    '{1'b0, 2'd2, 8'h00, 8'h00, 4'h0, 5'h00, 8'hFF, 4'd5},  // R5
    '{1'b1, 2'd2, 8'h00, 8'h00, 4'h0, 5'h00, 8'h00, 4'd5},
    '{1'b0, 2'd2, 8'h00, 8'h00, 4'h0, 5'h00, 8'hC0, 4'd5},  // R5 top ones kept
    '{1'b0, 2'd1, 8'h00, 8'h00, 4'h0, 5'h16, 8'h37, 4'd8},  // R8
    '{1'b0, 2'd1, 8'h00, 8'h00, 4'h0, 5'h00, 8'h87, 4'd8},  // R8
    '{1'b1, 2'd1, 8'h00, 8'h00, 4'h0, 5'h00, 8'h00, 4'd8},
    '{1'b0, 2'd0, 8'h00, 8'h00, 4'h0, 5'h00, 8'hA5, 4'd8},  // R8 write ignored
    '{1'b0, 2'd1, 8'h00, 8'h00, 4'h0, 5'h1F, 8'h7F, 4'd8}   // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [7:0]  dpin_out, dpin_oe, dpin_in;
  logic [3:0]  cpin_pull_low, cpin_in;
  logic [4:0]  stat_in = '0;
  logic [7:0]  ext_d = '0;
  logic [3:0]  ext_pull = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // pad model: driven bits loop back, released bits follow the device
  always_comb begin
    for (int i = 0; i < 8; i++) dpin_in[i] = dpin_oe[i] ? dpin_out[i] : ext_d[i];
    cpin_in = ~cpin_pull_low & ~ext_pull;
  end

  pport_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE)) uut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .dpin_out(dpin_out), .dpin_oe(dpin_oe), .dpin_in(dpin_in),
    .cpin_pull_low(cpin_pull_low), .cpin_in(cpin_in), .stat_in(stat_in)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // call at a falling edge; returns at the next falling edge
  task automatic xfer(input logic wr, input logic [15:0] addr, input logic [7:0] wd,
                      output logic v, output logic [7:0] d);
    bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_wdata = wd;
    @(negedge clk);
    v = rsp_valid; d = rsp_data;
    bus_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic       v;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset pin state, R10 ready held high
    check("R1 dpin_out", dpin_out, 8'h00);
    check("R1 dpin_oe", dpin_oe, 8'hFF);
    check("R1 cpin_pull_low", {4'h0, cpin_pull_low}, 8'h00);
    check("R10 bus_ready", {7'h0, bus_ready}, 8'h01);

    for (int k = 0; k < NV; k++) begin
      ext_d = VECS[k].ext; ext_pull = VECS[k].pull; stat_in = VECS[k].st;
      repeat (4) @(negedge clk);
      xfer(VECS[k].wr, BASE + 16'(VECS[k].off), VECS[k].wd, v, d);
      if (VECS[k].wr) begin
        check($sformatf("R10 vec %0d no write rsp", k), {7'h0, v}, 8'h00);
      end else begin
        check($sformatf("R%0d vec %0d valid", VECS[k].req, k), {7'h0, v}, 8'h01);
        check($sformatf("R%0d vec %0d data", VECS[k].req, k), d, VECS[k].exp);
      end
    end
    ext_d = '0; ext_pull = '0; stat_in = '0;
    repeat (4) @(negedge clk);

    // R3 write then back-to-back data reads (ctrl is 0x00: output mode, latch A5)
    xfer(1'b1, BASE, 8'h5A, v, d);
    check("R2 dpin_out after write", dpin_out, 8'h5A);
    xfer(1'b0, BASE, 8'h00, v, d);
    check("R3 first read old", d, 8'hA5);
    xfer(1'b0, BASE, 8'h00, v, d);
    check("R3 second read old", d, 8'hA5);
    xfer(1'b0, BASE, 8'h00, v, d);
    check("R3 third read new", d, 8'h5A);

    // R2 latch holds across control writes
    xfer(1'b1, BASE + 16'd2, 8'h10, v, d);
    check("R2 hold across ctrl write", dpin_out, 8'h5A);

    // R4 mode bit switches output enables
    xfer(1'b1, BASE + 16'd2, 8'h20, v, d);
    check("R4 input mode oe", dpin_oe, 8'h00);
    check("R2 latch kept in input mode", dpin_out, 8'h5A);
    xfer(1'b1, BASE + 16'd2, 8'h00, v, d);
    check("R4 output mode oe", dpin_oe, 8'hFF);

    // R6 control pin polarity
    xfer(1'b1, BASE + 16'd2, 8'h0B, v, d);
    check("R6 0x0B pulls all", {4'h0, cpin_pull_low}, 8'h0F);
    xfer(1'b1, BASE + 16'd2, 8'h01, v, d);
    check("R6 0x01", {4'h0, cpin_pull_low}, 8'h05);
    xfer(1'b1, BASE + 16'd2, 8'h04, v, d);
    check("R6 0x04 releases", {4'h0, cpin_pull_low}, 8'h00);

    // R9 undecoded offset 3
    xfer(1'b1, BASE + 16'd3, 8'h00, v, d);
    check("R9 write no rsp", {7'h0, v}, 8'h00);
    check("R9 data pins kept", dpin_out, 8'h5A);
    check("R9 ctrl pins kept", {4'h0, cpin_pull_low}, 8'h00);
    check("R9 oe kept", dpin_oe, 8'hFF);
    xfer(1'b0, BASE + 16'd3, 8'h00, v, d);
    check("R9 read no rsp", {7'h0, v}, 8'h00);
    xfer(1'b0, BASE - 16'd1, 8'h00, v, d);
    check("R9 below base no rsp", {7'h0, v}, 8'h00);

    // R10 response lasts one cycle only
    xfer(1'b0, BASE + 16'd1, 8'h00, v, d);
    check("R10 read rsp", {7'h0, v}, 8'h01);
    @(negedge clk);
    check("R10 rsp single cycle", {7'h0, rsp_valid}, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule